// File: doc/BRIEF.md
# Random Decoy Level Generator

The block produces one binary decoy level per qubit slot. A slot lasts a fixed number of fast-clock periods; with the default divider of three on a 240 MHz clock the slot rate is 80 MHz, one 12.5 ns slot per level. Each level is drawn from one of two random sources. The first is a pattern memory of 32-bit words that the host fills over AXI-Lite and that is replayed in a loop. The second is a live 4-bit random stream that supplies one nibble every four slots.

The undelayed level then passes through a coarse delay line. The delay is a whole number of fast-clock periods, at most eight. A small AXI-Lite register bank holds the run/apply bit, the coarse step, the source select and the last pattern word to read. The host writes new settings into shadow registers. They take effect together only when the run bit goes from 0 to 1, so a running generator never sees a half-updated configuration.

Top module: `decoy_level_gen`

## Requirements
- R1: AXI-Lite registers are at byte offsets 0x0 (run bit 0), 0x4 (coarse step bits 3:0), 0x8 (source select bit 0) and 0xC (last pattern word bits 5:0). Every write gets response OKAY (2'b00). Reads return the written value, with unused bits and unmapped offsets reading 0.
- R2: A step, source or last-word write changes the readback at once. It changes the generator only at the next 0-to-1 write of the run bit; until then the old delay and source stay in force.
- R3: While the run bit is 0, slot_tick and rng_pop stay 0 and decoy_raw is 0. Once the delay line has drained, decoy_level is also 0.
- R4: While running, slot_tick pulses for one cycle every SLOT_DIV (3) clock cycles. decoy_raw changes only in the cycle that slot_tick is high.
- R5: With source select 0, pattern word n is written at byte offset 0x1000 + 4·n. After the run bit rises, the levels are word 0 bit 0, then bit 1 and so on up to bit 31, then the next word, one bit per slot.
- R6: After the last bit of the word whose index equals the last-word register, reading wraps to word 0. Words beyond it are never emitted.
- R7: With source select 1, each nibble on rng_nibble supplies four consecutive slots, bit 0 first. rng_pop is high in the same cycle as slot_tick for the first of those four slots, and the next nibble is sampled at the next such slot.
- R8: decoy_level equals decoy_raw delayed by exactly the applied coarse step in clock cycles; a step of 0 passes the level straight through.
- R9: A coarse step greater than 8 acts as a step of 8.
- R10: After reset all registers read 0 and slot_tick, rng_pop, decoy_raw and decoy_level are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one coarse step is one period |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 13 | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | 13 | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| rng_nibble | input | 4 | Live random nibble |
| rng_pop | output | 1 | Current nibble consumed; present the next one |
| slot_tick | output | 1 | A new slot level is on decoy_raw |
| decoy_raw | output | 1 | Level before the coarse delay |
| decoy_level | output | 1 | Level after the coarse delay |

## Verification
A wrong bit or word pointer shows up on decoy_raw at the next slot tick, so a scoreboard of expected levels catches it within three cycles. A wrong wrap point appears one word (32 slots) after the last-word boundary. A wrong delay tap is visible on decoy_level in the very next cycle once decoy_raw has toggled, because decoy_level is compared every cycle against the bench's own history of decoy_raw. A setting that leaks through before the apply edge changes the delay or the source immediately, while the previous configuration is still expected.

// File: rtl/decoy_pkg.sv
package decoy_pkg;

   // Source select encoding held in the source register bit 0
   typedef enum logic {
      SRC_PATTERN = 1'b0,
      SRC_LIVE    = 1'b1
   } decoy_src_e;

   // Register word index, byte offset = 4 * index
   typedef enum logic [1:0] {
      REG_RUN   = 2'd0,
      REG_STEP  = 2'd1,
      REG_SRC   = 2'd2,
      REG_LAST  = 2'd3
   } decoy_reg_e;

   localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/decoy_regs.sv
module decoy_regs
   import decoy_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 32,
   parameter int STEP_W = 4,
   parameter int PTR_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic              run_o,
   output logic [STEP_W-1:0] act_step_o,
   output logic              act_live_o,
   output logic [PTR_W-1:0]  act_last_o,
   output logic              ram_we_o,
   output logic [PTR_W-1:0]  ram_waddr_o,
   output logic [DATA_W-1:0] ram_wdata_o
);

   localparam int RAM_BIT = ADDR_W - 1;

   if (PTR_W + 2 > RAM_BIT) begin : g_bad_addr
      $error("decoy_regs: address too narrow for pattern window");
   end
   if (STEP_W > DATA_W || PTR_W > DATA_W) begin : g_bad_field
      $error("decoy_regs: field wider than data bus");
   end

   logic              bvalid_q, rvalid_q;
   logic [DATA_W-1:0] rdata_q;
   logic              run_q;
   logic [STEP_W-1:0] sh_step, act_step;
   logic              sh_live, act_live;
   logic [PTR_W-1:0]  sh_last, act_last;

   logic wr_fire, rd_fire, wr_reg_hit, rd_reg_hit, wr_ram_hit;
   decoy_reg_e wr_idx, rd_idx;

   assign wr_fire    = s_awvalid & s_wvalid & ~bvalid_q;
   assign rd_fire    = s_arvalid & ~rvalid_q;
   assign wr_ram_hit = s_awaddr[RAM_BIT];
   assign wr_reg_hit = ~s_awaddr[RAM_BIT] & (s_awaddr[RAM_BIT-1:4] == '0);
   assign rd_reg_hit = ~s_araddr[RAM_BIT] & (s_araddr[RAM_BIT-1:4] == '0);
   assign wr_idx     = decoy_reg_e'(s_awaddr[3:2]);
   assign rd_idx     = decoy_reg_e'(s_araddr[3:2]);

   assign s_awready = wr_fire;
   assign s_wready  = wr_fire;
   assign s_bvalid  = bvalid_q;
   assign s_bresp   = RESP_OKAY;
   assign s_arready = rd_fire;
   assign s_rvalid  = rvalid_q;
   assign s_rresp   = RESP_OKAY;
   assign s_rdata   = rdata_q;

   assign ram_we_o    = wr_fire & wr_ram_hit;
   assign ram_waddr_o = s_awaddr[PTR_W+1:2];
   assign ram_wdata_o = s_wdata;

   assign run_o      = run_q;
   assign act_step_o = act_step;
   assign act_live_o = act_live;
   assign act_last_o = act_last;

   // Write channel, shadow registers and apply on run rising
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bvalid_q <= 1'b0;
         run_q    <= 1'b0;
         sh_step  <= '0;
         sh_live  <= 1'b0;
         sh_last  <= '0;
         act_step <= '0;
         act_live <= 1'b0;
         act_last <= '0;
      end else begin
         if (wr_fire) begin
            bvalid_q <= 1'b1;
         end else if (s_bready) begin
            bvalid_q <= 1'b0;
         end
         if (wr_fire && wr_reg_hit) begin
            unique case (wr_idx)
               REG_RUN: begin
                  run_q <= s_wdata[0];
                  if (s_wdata[0] && !run_q) begin
                     act_step <= sh_step;
                     act_live <= sh_live;
                     act_last <= sh_last;
                  end
               end
               REG_STEP: sh_step <= s_wdata[STEP_W-1:0];
               REG_SRC:  sh_live <= s_wdata[0];
               REG_LAST: sh_last <= s_wdata[PTR_W-1:0];
               default:  ;
            endcase
         end
      end
   end

   // Read channel
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         if (rd_fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= '0;
            if (rd_reg_hit) begin
               unique case (rd_idx)
                  REG_RUN:  rdata_q[0]          <= run_q;
                  REG_STEP: rdata_q[STEP_W-1:0] <= sh_step;
                  REG_SRC:  rdata_q[0]          <= sh_live;
                  REG_LAST: rdata_q[PTR_W-1:0]  <= sh_last;
                  default:  ;
               endcase
            end
         end else if (s_rready) begin
            rvalid_q <= 1'b0;
         end
      end
   end

   p_bvalid_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid && !s_bready |=> s_bvalid);
   p_rvalid_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
   p_apply_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_step) || !$stable(act_live) || !$stable(act_last) |-> $rose(run_q));

endmodule

// File: rtl/decoy_pattern_ram.sv
module decoy_pattern_ram #(
   parameter int WORDS  = 64,
   parameter int DATA_W = 32,
   parameter int PTR_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [PTR_W-1:0]  waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [PTR_W-1:0]  raddr_i,
   output logic [DATA_W-1:0] rdata_o
);

   if (WORDS > (1 << PTR_W)) begin : g_bad_depth
      $error("decoy_pattern_ram: pointer too narrow for depth");
   end

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) begin
            mem[i] <= '0;
         end
      end else if (we_i && (int'(waddr_i) < WORDS)) begin
         mem[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = (int'(raddr_i) < WORDS) ? mem[raddr_i] : '0;

endmodule

// File: rtl/decoy_serializer.sv
module decoy_serializer #(
   parameter int DATA_W   = 32,
   parameter int PTR_W    = 6,
   parameter int NIB_W    = 4,
   parameter int SLOT_DIV = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              live_i,
   input  logic [PTR_W-1:0]  last_i,
   output logic [PTR_W-1:0]  raddr_o,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [NIB_W-1:0]  nibble_i,
   output logic              pop_o,
   output logic              tick_o,
   output logic              raw_o
);

   localparam int DIV_W  = $clog2(SLOT_DIV);
   localparam int BIT_W  = $clog2(DATA_W);
   localparam int NCNT_W = $clog2(NIB_W);

   if (SLOT_DIV < 2) begin : g_bad_div
      $error("decoy_serializer: slot divider must be at least 2");
   end
   if (NIB_W < 2 || DATA_W < 2) begin : g_bad_width
      $error("decoy_serializer: source widths must be at least 2");
   end

   logic [DIV_W-1:0]  div_q;
   logic [PTR_W-1:0]  wptr_q;
   logic [BIT_W-1:0]  bptr_q;
   logic [NCNT_W-1:0] ncnt_q;
   logic [NIB_W-1:0]  nib_q;
   logic              raw_q, tick_q, pop_q;
   logic              slot_stb;

   assign slot_stb = run_i && (div_q == DIV_W'(SLOT_DIV - 1));
   assign raddr_o  = wptr_q;
   assign raw_o    = raw_q;
   assign tick_o   = tick_q;
   assign pop_o    = pop_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) begin
         div_q  <= '0;
         wptr_q <= '0;
         bptr_q <= '0;
         ncnt_q <= '0;
         nib_q  <= '0;
         raw_q  <= 1'b0;
         tick_q <= 1'b0;
         pop_q  <= 1'b0;
      end else begin
         div_q  <= slot_stb ? '0 : div_q + 1'b1;
         tick_q <= slot_stb;
         pop_q  <= slot_stb && live_i && (ncnt_q == '0);
         if (slot_stb) begin
            if (live_i) begin
               if (ncnt_q == '0) begin
                  raw_q <= nibble_i[0];
                  nib_q <= nibble_i;
               end else begin
                  raw_q <= nib_q[ncnt_q];
               end
               ncnt_q <= (ncnt_q == NCNT_W'(NIB_W - 1)) ? '0 : ncnt_q + 1'b1;
            end else begin
               raw_q <= rdata_i[bptr_q];
               if (bptr_q == BIT_W'(DATA_W - 1)) begin
                  bptr_q <= '0;
                  wptr_q <= (wptr_q == last_i) ? '0 : wptr_q + 1'b1;
               end else begin
                  bptr_q <= bptr_q + 1'b1;
               end
            end
         end
      end
   end

   p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
   p_raw_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run_i && $past(run_i) && !tick_o |-> $stable(raw_o));
   p_pop_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pop_o |-> tick_o && live_i);
   p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> wptr_q <= last_i);
   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !tick_o && !pop_o && !raw_o);

endmodule

// File: rtl/decoy_coarse_delay.sv
module decoy_coarse_delay #(
   parameter int STEP_W   = 4,
   parameter int MAX_STEP = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STEP_W-1:0] step_i,
   input  logic              din_i,
   output logic              dout_o
);

   if (MAX_STEP >= (1 << STEP_W)) begin : g_bad_step
      $error("decoy_coarse_delay: step field too narrow for MAX_STEP");
   end

   logic [STEP_W-1:0] step_eff;

   assign step_eff = (step_i > STEP_W'(MAX_STEP)) ? STEP_W'(MAX_STEP) : step_i;

   if (MAX_STEP == 0) begin : g_pass
      assign dout_o = din_i;
   end else begin : g_line
      logic [MAX_STEP-1:0] line_q;
      logic                tap [MAX_STEP+1];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            line_q <= '0;
         end else begin
            line_q[0] <= din_i;
            for (int i = 1; i < MAX_STEP; i++) begin
               line_q[i] <= line_q[i-1];
            end
         end
      end

      always_comb begin
         tap[0] = din_i;
         for (int i = 1; i <= MAX_STEP; i++) begin
            tap[i] = line_q[i-1];
         end
      end

      assign dout_o = tap[step_eff];

      p_one_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (step_i == STEP_W'(1)) && $stable(step_i) |-> dout_o == $past(din_i));
   end

   p_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i > STEP_W'(MAX_STEP)) |-> (step_eff == STEP_W'(MAX_STEP)));

endmodule

// File: rtl/decoy_level_gen.sv
module decoy_level_gen
   import decoy_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int DATA_W   = 32,
   parameter int WORDS    = 64,
   parameter int NIB_W    = 4,
   parameter int STEP_W   = 4,
   parameter int MAX_STEP = 8,
   parameter int SLOT_DIV = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   input  logic [NIB_W-1:0]  rng_nibble,
   output logic              rng_pop,
   output logic              slot_tick,
   output logic              decoy_raw,
   output logic              decoy_level
);

   localparam int PTR_W = $clog2(WORDS);

   if (DATA_W != 32) begin : g_bad_bus
      $error("decoy_level_gen: AXI-Lite data width must be 32");
   end

   logic              run;
   logic [STEP_W-1:0] act_step;
   logic              act_live;
   logic [PTR_W-1:0]  act_last;
   logic              ram_we;
   logic [PTR_W-1:0]  ram_waddr, ram_raddr;
   logic [DATA_W-1:0] ram_wdata, ram_rdata;

   decoy_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .STEP_W (STEP_W),
      .PTR_W  (PTR_W)
   ) i_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .s_awaddr    (s_awaddr),
      .s_awvalid   (s_awvalid),
      .s_awready   (s_awready),
      .s_wdata     (s_wdata),
      .s_wvalid    (s_wvalid),
      .s_wready    (s_wready),
      .s_bresp     (s_bresp),
      .s_bvalid    (s_bvalid),
      .s_bready    (s_bready),
      .s_araddr    (s_araddr),
      .s_arvalid   (s_arvalid),
      .s_arready   (s_arready),
      .s_rdata     (s_rdata),
      .s_rresp     (s_rresp),
      .s_rvalid    (s_rvalid),
      .s_rready    (s_rready),
      .run_o       (run),
      .act_step_o  (act_step),
      .act_live_o  (act_live),
      .act_last_o  (act_last),
      .ram_we_o    (ram_we),
      .ram_waddr_o (ram_waddr),
      .ram_wdata_o (ram_wdata)
   );

   decoy_pattern_ram #(
      .WORDS  (WORDS),
      .DATA_W (DATA_W),
      .PTR_W  (PTR_W)
   ) i_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (ram_we),
      .waddr_i (ram_waddr),
      .wdata_i (ram_wdata),
      .raddr_i (ram_raddr),
      .rdata_o (ram_rdata)
   );

   decoy_serializer #(
      .DATA_W   (DATA_W),
      .PTR_W    (PTR_W),
      .NIB_W    (NIB_W),
      .SLOT_DIV (SLOT_DIV)
   ) i_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run),
      .live_i   (act_live),
      .last_i   (act_last),
      .raddr_o  (ram_raddr),
      .rdata_i  (ram_rdata),
      .nibble_i (rng_nibble),
      .pop_o    (rng_pop),
      .tick_o   (slot_tick),
      .raw_o    (decoy_raw)
   );

   decoy_coarse_delay #(
      .STEP_W   (STEP_W),
      .MAX_STEP (MAX_STEP)
   ) i_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (act_step),
      .din_i  (decoy_raw),
      .dout_o (decoy_level)
   );

   p_write_okay_r1: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid |-> s_bresp == RESP_OKAY);

endmodule

// File: tb/test_decoy_level_gen.sv
module test_decoy_level_gen;

   localparam int ADDR_W = 13;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] s_awaddr = '0;
   logic              s_awvalid = 1'b0;
   logic              s_awready;
   logic [31:0]       s_wdata = '0;
   logic              s_wvalid = 1'b0;
   logic              s_wready;
   logic [1:0]        s_bresp;
   logic              s_bvalid;
   logic              s_bready = 1'b1;
   logic [ADDR_W-1:0] s_araddr = '0;
   logic              s_arvalid = 1'b0;
   logic              s_arready;
   logic [31:0]       s_rdata;
   logic [1:0]        s_rresp;
   logic              s_rvalid;
   logic              s_rready = 1'b1;
   logic [3:0]        rng_nibble;
   logic              rng_pop;
   logic              slot_tick;
   logic              decoy_raw;
   logic              decoy_level;

   always #2.5 clk = ~clk;

   decoy_level_gen i_decoy_level_gen (
      .clk, .rst_n,
      .s_awaddr, .s_awvalid, .s_awready, .s_wdata, .s_wvalid, .s_wready,
      .s_bresp, .s_bvalid, .s_bready,
      .s_araddr, .s_arvalid, .s_arready, .s_rdata, .s_rresp, .s_rvalid, .s_rready,
      .rng_nibble, .rng_pop, .slot_tick, .decoy_raw, .decoy_level
   );

   int errors = 0;
   int checks = 0;
   int cycle  = 0;

   // Bench model of settings
   int  m_run = 0;
   int  m_step = 0;
   int  exp_step = 0;

   // Scoreboard
   bit  exp_q[$];
   bit  sb_on = 1'b0;
   int  sb_hits = 0;
   int  last_tick = -1;
   bit  live_on = 1'b0;
   int  nib_idx = 0;
   int  tick_idx = 0;
   int  pop_count = 0;
   bit  hist [0:8];

   function automatic logic [3:0] nib_val(int i);
      return 4'((i * 11 + 5) ^ (i >> 1));
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp_v, cycle);
      end
   endtask

   task automatic axi_write(logic [ADDR_W-1:0] a, logic [31:0] d);
      @(negedge clk);
      s_awaddr = a; s_wdata = d; s_awvalid = 1'b1; s_wvalid = 1'b1;
      @(posedge clk);
      if (a == 13'h004) m_step = int'(d[3:0]);
      if (a == 13'h000) begin
         if (d[0] && m_run == 0) exp_step = (m_step > 8) ? 8 : m_step;
         m_run = int'(d[0]);
      end
      @(negedge clk);
      s_awvalid = 1'b0; s_wvalid = 1'b0;
      check(s_bvalid && s_bresp == 2'b00, "R1 write response", {30'd0, s_bresp}, 32'd0);
   endtask

   task automatic axi_read(logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      s_araddr = a; s_arvalid = 1'b1;
      @(negedge clk);
      s_arvalid = 1'b0;
      d = s_rdata;
   endtask

   task automatic push_word(logic [31:0] w);
      for (int b = 0; b < 32; b++) exp_q.push_back(w[b]);
   endtask

   task automatic push_nib(logic [3:0] n);
      for (int b = 0; b < 4; b++) exp_q.push_back(n[b]);
   endtask

   // Monitor: scoreboard pops, tick spacing, pop alignment, delay tracking, live driver
   always @(negedge clk) begin
      cycle++;
      for (int k = 8; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = decoy_raw;
      if (rst_n) begin
         // R8/R9: delayed output follows own history of the raw level
         check(decoy_level == hist[exp_step], "R8/R9 delay tap",
               {31'd0, decoy_level}, {31'd0, hist[exp_step]});
      end
      if (slot_tick) begin
         if (last_tick >= 0 && m_run != 0)
            check(cycle - last_tick == 3, "R4 slot spacing", cycle - last_tick, 3);
         last_tick = cycle;
         if (sb_on && exp_q.size() > 0) begin
            bit e;
            e = exp_q.pop_front();
            sb_hits++;
            check(decoy_raw == e, live_on ? "R7 live level" : "R5/R6 pattern level",
                  {31'd0, decoy_raw}, {31'd0, e});
         end
         if (live_on) begin
            check(rng_pop == ((tick_idx % 4) == 0), "R7 pop alignment",
                  {31'd0, rng_pop}, {31'd0, (tick_idx % 4) == 0});
            tick_idx++;
         end
      end else begin
         if (m_run == 0 && rst_n) begin
            last_tick = -1;
         end
      end
      if (!live_on) begin
         nib_idx = 0;
         rng_nibble = nib_val(0);
      end else if (rng_pop) begin
         pop_count++;
         nib_idx++;
         rng_nibble = nib_val(nib_idx);
         push_nib(nib_val(nib_idx));
      end
   end

   // Watchdog
   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   logic [31:0] words [4];
   initial begin
      logic [31:0] rd;
      words[0] = 32'hA5C3_0F96;
      words[1] = 32'h1234_8001;
      words[2] = 32'hFFFF_0000;
      words[3] = 32'hDEAD_BEEF;

      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      check(!slot_tick && !rng_pop && !decoy_raw && !decoy_level, "R10 outputs after reset",
            {28'd0, slot_tick, rng_pop, decoy_raw, decoy_level}, 32'd0);
      for (int r = 0; r < 4; r++) begin
         axi_read(ADDR_W'(4 * r), rd);
         check(rd == 32'd0, "R10 register reset", rd, 32'd0);
      end

      // R1: readback, unused bits, unmapped offset
      axi_write(13'h004, 32'hFFFF_FFFF);
      axi_read(13'h004, rd);
      check(rd == 32'h0000_000F, "R1 step readback", rd, 32'h0000_000F);
      axi_write(13'h008, 32'hFFFF_FFFE);
      axi_read(13'h008, rd);
      check(rd == 32'd0, "R1 source unused bits", rd, 32'd0);
      axi_write(13'h00C, 32'hFFFF_FFC2);
      axi_read(13'h00C, rd);
      check(rd == 32'h0000_0002, "R1 last-word readback", rd, 32'h0000_0002);
      axi_read(13'h040, rd);
      check(rd == 32'd0, "R1 unmapped offset", rd, 32'd0);

      // R5: load pattern words
      for (int w = 0; w < 4; w++) axi_write(ADDR_W'(13'h1000 + 4 * w), words[w]);
      axi_write(13'h004, 32'd2);
      axi_write(13'h008, 32'd0);

      // R3: idle before run
      repeat (10) begin
         @(negedge clk);
         check(!slot_tick && !decoy_raw, "R3 idle before run",
               {30'd0, slot_tick, decoy_raw}, 32'd0);
      end

      // R5/R6: two loops over words 0..2, word 3 never emitted
      for (int l = 0; l < 2; l++)
         for (int w = 0; w < 3; w++) push_word(words[w]);
      sb_hits = 0;
      sb_on = 1'b1;
      axi_write(13'h000, 32'd1);
      repeat (100) @(negedge clk);
      // R2: shadow write does not touch the running delay
      axi_write(13'h004, 32'd5);
      axi_read(13'h004, rd);
      check(rd == 32'd5, "R2 shadow readback", rd, 32'd5);
      while (exp_q.size() > 0) @(negedge clk);
      sb_on = 1'b0;
      check(sb_hits == 192, "R6 pattern slot count", sb_hits, 192);
      check(exp_step == 2, "R2 old step kept", exp_step, 2);

      // R2: apply new step on rising run
      axi_write(13'h000, 32'd0);
      axi_write(13'h000, 32'd1);
      repeat (40) @(negedge clk);

      // R9: step above 8 clamps
      axi_write(13'h004, 32'd12);
      axi_write(13'h000, 32'd0);
      axi_write(13'h000, 32'd1);
      repeat (60) @(negedge clk);

      // R3: idle after stop
      axi_write(13'h000, 32'd0);
      repeat (12) @(negedge clk);
      repeat (6) begin
         @(negedge clk);
         check(!slot_tick && !rng_pop && !decoy_raw && !decoy_level, "R3 idle after stop",
               {29'd0, slot_tick, decoy_raw, decoy_level}, 32'd0);
      end

      // R7: live nibble stream, step 0
      axi_write(13'h004, 32'd0);
      axi_write(13'h008, 32'd1);
      exp_q.delete();
      push_nib(nib_val(0));
      tick_idx = 0;
      pop_count = 0;
      sb_hits = 0;
      live_on = 1'b1;
      sb_on = 1'b1;
      axi_write(13'h000, 32'd1);
      while (nib_idx < 10) @(negedge clk);
      sb_on = 1'b0;
      axi_write(13'h000, 32'd0);
      live_on = 1'b0;
      exp_q.delete();
      check(pop_count == 10, "R7 nibble pops", pop_count, 10);
      check(sb_hits >= 36, "R7 live slot count", sb_hits, 36);

      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule